// File: doc/BRIEF.md
# Duty-Cycle Sync Marker Link

This block carries a rare synchronization event on a forwarded clock line without adding a second wire. The transmitter runs on a fast clock ten times the line rate. It normally drives a line period that is high for three fast ticks and low for seven. When a sync is requested, it stretches one period to seven ticks high and three low. Every period, including the stretched one, starts with a rising edge in the same place.

The receiver keeps its own phase count, aligned to the shared reference. It reads the line level once, in the middle of each period. In a normal period it reads low. In a stretched period it reads high.

The receiver produces a strobe that lasts exactly one full line period. The strobe appears in the period after the sample that detected the event. Two DC-balanced variants are selected by a mode input. The first is a couplet: two stretched periods framed by normal ones, with the receiver checking the framing. The second is a continuous square envelope of 50 normal and 50 stretched periods, and each edge of the envelope counts as an event.

Top module: `dcs_link`

Mode encoding on `mode`: 0 = single marker, 1 = balanced couplet, 2 = square envelope, 3 = same as 0.

Transmitter states:
- TX_IDLE: normal duty.
- TX_SYNC_A: stretched period.
- TX_SYNC_B: second stretched period of a couplet.
- TX_TAIL: closing normal period of a couplet.
- TX_SQ_LO: envelope, normal half.
- TX_SQ_HI: envelope, stretched half.

Transmitter transitions, all taken only at the last tick of a period:
- idle→sync_a: a request is pending.
- sync_a→sync_b: mode is couplet.
- sync_a→sync_a: single mode and another request is pending.
- sync_a→idle: single mode and no request is pending.
- sync_b→tail: always.
- tail→sync_a or tail→idle: according to whether a request is pending.
- any→sq_lo: mode is square and the state is not an envelope state.
- sq_lo↔sq_hi: after 50 periods in the current half.
- sq_*→idle: mode has left square.

Receiver states:
- RX_IDLE: waiting for a high sample.
- RX_PAIR: expecting a second high sample.
- RX_TRAIL: expecting a low sample.

Receiver transitions, all taken at the sample tick and only in couplet mode:
- idle→pair: high sample, which is reported as the event.
- pair→trail: high sample.
- pair→idle: low sample, which is an error.
- trail→idle: always; a high sample here is an error.

## Requirements
- R1: During and after reset with no request, `line_out` repeats a 10-tick period: high for 3 ticks, then low for 7. It is low while `rst` is high.
- R2: In single mode, one `sync_req` pulse produces exactly one period that is high for 7 ticks. The rising edges stay exactly 10 ticks apart.
- R3: For each stretched period in single mode, `sync_strobe` rises 2 ticks after that period's falling edge. It stays high for exactly 10 ticks, one strobe per event.
- R4: A request that arrives at any tick of a period waits for the next period boundary. Every high run is then 3 or 7 ticks, and every period stays 10 ticks long.
- R5: In couplet mode, one request produces the high runs 7, 7, 3 on consecutive periods. The receiver gives one strobe and no error.
- R6: In couplet mode, if a first high sample is followed by a low sample, or by two further high samples, `pattern_err` goes high for exactly 10 ticks. No second strobe is raised, and the strobe and the error are never high together.
- R7: In square mode, the line alternates 50 normal and 50 stretched periods. The receiver strobes on each envelope edge, 500 ticks apart.
- R8: `sync_req` has no effect in square mode. No stretched period follows after leaving square mode.
- R9: A synchronous reset in the middle of a stretched period forces the normal 3-of-10 waveform from then on, and no strobe is raised for the cut period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, ten ticks per line period |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 0 single, 1 couplet, 2 square envelope, 3 single |
| sync_req | input | 1 | Request one sync event (single-tick pulse) |
| line_out | output | 1 | Transmitted duty-coded clock line |
| line_in | input | 1 | Received line, sampled at mid-period |
| sync_strobe | output | 1 | One-period sync strobe |
| pattern_err | output | 1 | One-period couplet framing error |

## Verification
The hardest case to reach from the ports is the receiver's framing error. A correct transmitter never sends a broken couplet. To get there, the bench locks onto a rising edge of `line_out` and then switches `line_in` to a waveform it generates itself, period by period. This lets it send one stretched period followed by a normal one, or three stretched periods in a row. A second hard case is a request landing at each of the ten ticks of a period. The bench aligns to a rising edge and delays the pulse by 0 to 9 ticks, so every tick is covered.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_COUPLET = 2'd1,
        MODE_SQUARE  = 2'd2,
        MODE_RSVD    = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SYNC_A,
        TX_SYNC_B,
        TX_TAIL,
        TX_SQ_LO,
        TX_SQ_HI
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_PAIR,
        RX_TRAIL
    } rx_state_e;

endpackage

// File: rtl/dcs_phase.sv
module dcs_phase #(
    parameter int PHASES = 10,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output logic            ph_last
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    assign ph_last = (ph == LAST);

    always_ff @(posedge clk) begin
        if (rst)          ph <= '0;
        else if (ph_last) ph <= '0;
        else              ph <= ph + 1'b1;
    end

endmodule

// File: rtl/dcs_tx.sv
module dcs_tx
    import dcs_pkg::*;
#(
    parameter int PHASES  = 10,
    parameter int HI_NORM = 3,
    parameter int HI_SYNC = 7,
    parameter int SQ_LEN  = 50,
    parameter int PH_W    = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    input  mode_e           mode,
    input  logic            req,
    input  logic [PH_W-1:0] ph,
    input  logic            ph_last,
    output logic            line
);
    localparam int SQ_W = (SQ_LEN > 1) ? $clog2(SQ_LEN) : 1;
    localparam logic [PH_W-1:0] HI_N = PH_W'(HI_NORM);
    localparam logic [PH_W-1:0] HI_S = PH_W'(HI_SYNC);
    localparam logic [SQ_W-1:0] SQ_END = SQ_W'(SQ_LEN - 1);

    tx_state_e       state_q, nxt;
    logic            pend_q;
    logic [SQ_W-1:0] sq_cnt;
    logic            want, take, sq_end, stretched, in_sq;
    logic [PH_W-1:0] hi_cur;

    assign want      = pend_q | req;
    assign sq_end    = (sq_cnt == SQ_END);
    assign in_sq     = (state_q == TX_SQ_LO) || (state_q == TX_SQ_HI);
    assign stretched = (state_q == TX_SYNC_A) || (state_q == TX_SYNC_B) ||
                       (state_q == TX_SQ_HI);
    assign hi_cur    = stretched ? HI_S : HI_N;

    // Next state: only at a period boundary, so no period is cut (R4)
    always_comb begin
        nxt  = state_q;
        take = 1'b0;
        if (ph_last) begin
            if (mode == MODE_SQUARE) begin
                unique case (state_q)
                    TX_SQ_LO: if (sq_end) nxt = TX_SQ_HI;
                    TX_SQ_HI: if (sq_end) nxt = TX_SQ_LO;
                    default:  nxt = TX_SQ_LO;
                endcase
            end else begin
                unique case (state_q)
                    TX_IDLE: begin
                        if (want) begin
                            nxt  = TX_SYNC_A;
                            take = 1'b1;
                        end
                    end
                    TX_SYNC_A: begin
                        if (mode == MODE_COUPLET) begin
                            nxt = TX_SYNC_B;
                        end else if (want) begin
                            nxt  = TX_SYNC_A;
                            take = 1'b1;
                        end else begin
                            nxt = TX_IDLE;
                        end
                    end
                    TX_SYNC_B: nxt = TX_TAIL;
                    TX_TAIL: begin
                        if (want) begin
                            nxt  = TX_SYNC_A;
                            take = 1'b1;
                        end else begin
                            nxt = TX_IDLE;
                        end
                    end
                    default: nxt = TX_IDLE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= nxt;
    end

    // Outputs and per-state bookkeeping (R1, R2, R7, R8, R9)
    always_ff @(posedge clk) begin
        if (rst) begin
            line   <= 1'b0;
            pend_q <= 1'b0;
            sq_cnt <= '0;
        end else begin
            line <= (ph < hi_cur);
            if (mode == MODE_SQUARE) pend_q <= 1'b0;
            else                     pend_q <= want & ~take;
            if (ph_last) begin
                if (!in_sq || (nxt != state_q)) sq_cnt <= '0;
                else                            sq_cnt <= sq_cnt + 1'b1;
            end
        end
    end

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_W'(1)) |-> line);  // R1
    AST_LOW_BEFORE_END: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_W'(PHASES - 2)) |-> !line);  // R2
    AST_NO_MIDCYCLE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (ph != '0) |-> (state_q == $past(state_q)));  // R4
    AST_SQUARE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SQUARE) |=> !pend_q);  // R8

endmodule

// File: rtl/dcs_rx.sv
module dcs_rx
    import dcs_pkg::*;
#(
    parameter int PHASES    = 10,
    parameter int SAMPLE_PH = 5,
    parameter int PH_W      = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    input  mode_e           mode,
    input  logic            line_in,
    input  logic [PH_W-1:0] ph,
    input  logic            ph_last,
    output logic            sync_o,
    output logic            err_o
);
    localparam logic [PH_W-1:0] SAMP = PH_W'(SAMPLE_PH);

    rx_state_e state_q, nxt;
    logic      samp, prev_lvl, evt, err, evt_pend, err_pend;

    assign samp = (ph == SAMP);

    // Next state and per-sample decisions (R3, R5, R6, R7)
    always_comb begin
        nxt = state_q;
        evt = 1'b0;
        err = 1'b0;
        if (samp) begin
            if (mode == MODE_COUPLET) begin
                unique case (state_q)
                    RX_IDLE: begin
                        if (line_in) begin
                            evt = 1'b1;
                            nxt = RX_PAIR;
                        end
                    end
                    RX_PAIR: begin
                        if (line_in) begin
                            nxt = RX_TRAIL;
                        end else begin
                            err = 1'b1;
                            nxt = RX_IDLE;
                        end
                    end
                    RX_TRAIL: begin
                        err = line_in;
                        nxt = RX_IDLE;
                    end
                    default: nxt = RX_IDLE;
                endcase
            end else begin
                nxt = RX_IDLE;
                if (mode == MODE_SQUARE) evt = line_in ^ prev_lvl;
                else                     evt = line_in;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= nxt;
    end

    // Outputs: published for the whole period after the sample
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= 1'b0;
            evt_pend <= 1'b0;
            err_pend <= 1'b0;
            sync_o   <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            if (samp) begin
                prev_lvl <= line_in;
                evt_pend <= evt;
                err_pend <= err;
            end
            if (ph_last) begin
                sync_o <= evt_pend;
                err_o  <= err_pend;
            end
        end
    end

    AST_STROBE_FRAMED: assert property (@(posedge clk) disable iff (rst)
        (ph != '0) |-> $stable(sync_o));  // R3
    AST_ERR_FRAMED: assert property (@(posedge clk) disable iff (rst)
        (ph != '0) |-> $stable(err_o));  // R6
    AST_SYNC_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sync_o && err_o));  // R6

endmodule

// File: rtl/dcs_link.sv
module dcs_link
    import dcs_pkg::*;
#(
    parameter int PHASES    = 10,
    parameter int HI_NORM   = 3,
    parameter int HI_SYNC   = 7,
    parameter int SAMPLE_PH = PHASES / 2,
    parameter int SQ_LEN    = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       sync_req,
    output logic       line_out,
    input  logic       line_in,
    output logic       sync_strobe,
    output logic       pattern_err
);
    localparam int PH_W = $clog2(PHASES);

    mode_e           mode_q;
    logic [PH_W-1:0] tx_ph, rx_ph;
    logic            tx_last, rx_last;

    assign mode_q = mode_e'(mode);

    dcs_phase #(.PHASES(PHASES), .PH_W(PH_W)) u_tx_ref (
        .clk(clk), .rst(rst), .ph(tx_ph), .ph_last(tx_last)
    );

    dcs_phase #(.PHASES(PHASES), .PH_W(PH_W)) u_rx_ref (
        .clk(clk), .rst(rst), .ph(rx_ph), .ph_last(rx_last)
    );

    dcs_tx #(
        .PHASES(PHASES), .HI_NORM(HI_NORM), .HI_SYNC(HI_SYNC),
        .SQ_LEN(SQ_LEN), .PH_W(PH_W)
    ) u_tx (
        .clk(clk), .rst(rst), .mode(mode_q), .req(sync_req),
        .ph(tx_ph), .ph_last(tx_last), .line(line_out)
    );

    dcs_rx #(.PHASES(PHASES), .SAMPLE_PH(SAMPLE_PH), .PH_W(PH_W)) u_rx (
        .clk(clk), .rst(rst), .mode(mode_q), .line_in(line_in),
        .ph(rx_ph), .ph_last(rx_last), .sync_o(sync_strobe), .err_o(pattern_err)
    );

endmodule

// File: tb/tb_dcs_link.sv
module tb_dcs_link;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       sync_req = 1'b0;
    logic       line_out, line_in, sync_strobe, pattern_err;
    logic       inj_en = 1'b0;
    logic       inj_line = 1'b0;

    assign line_in = inj_en ? inj_line : line_out;

    always #10 clk = ~clk;

    dcs_link dut (
        .clk(clk), .rst(rst), .mode(mode), .sync_req(sync_req),
        .line_out(line_out), .line_in(line_in),
        .sync_strobe(sync_strobe), .pattern_err(pattern_err)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;
    int last_rise = -1, last_fall7 = -1, s_rise = -1, e_rise = -1;
    int n3 = 0, n7 = 0, bad_run = 0, bad_per = 0;
    int n_strobe = 0, n_perr = 0, last_delta = -1, last_slen = -1, last_elen = -1;
    int sp_ok = 0, sp_bad = 0, nrun = 0;
    int runlog [16];
    logic pl = 1'b0, ps = 1'b0, pe = 1'b0;

    // Port monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (line_out && !pl) begin
            if (last_rise >= 0 && cyc - last_rise != 10) bad_per++;
            last_rise = cyc;
        end
        if (!line_out && pl && last_rise >= 0) begin
            if (cyc - last_rise == 3) n3++;
            else if (cyc - last_rise == 7) begin
                n7++;
                last_fall7 = cyc;
            end else bad_run++;
            if (nrun < 16) runlog[nrun] = cyc - last_rise;
            nrun++;
        end
        if (sync_strobe && !ps) begin
            n_strobe++;
            last_delta = (last_fall7 >= 0) ? cyc - last_fall7 : -1;
            if (s_rise >= 0) begin
                if (cyc - s_rise == 500) sp_ok++;
                else sp_bad++;
            end
            s_rise = cyc;
        end
        if (!sync_strobe && ps && s_rise >= 0) last_slen = cyc - s_rise;
        if (pattern_err && !pe) begin
            n_perr++;
            e_rise = cyc;
        end
        if (!pattern_err && pe && e_rise >= 0) last_elen = cyc - e_rise;
        pl = line_out;
        ps = sync_strobe;
        pe = pattern_err;
    end

    task automatic clear_mon();
        @(posedge clk);
        #1;
        last_rise = -1; last_fall7 = -1; s_rise = -1; e_rise = -1;
        n3 = 0; n7 = 0; bad_run = 0; bad_per = 0;
        n_strobe = 0; n_perr = 0; last_delta = -1; last_slen = -1; last_elen = -1;
        sp_ok = 0; sp_bad = 0; nrun = 0;
        for (int i = 0; i < 16; i++) runlog[i] = 0;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk) sync_req = 1'b1;
        @(negedge clk) sync_req = 1'b0;
    endtask

    task automatic wait_rise();
        logic pv;
        bit   hit;
        pv = line_out;
        hit = 0;
        while (!hit) begin
            @(negedge clk);
            hit = line_out && !pv;
            pv = line_out;
        end
    endtask

    // Drive line_in with bench-made periods aligned to line_out
    task automatic inj_seq(input int his [5], input int n);
        inj_line = 1'b0;
        inj_en = 1'b1;
        wait_rise();
        for (int p = 0; p < n; p++) begin
            for (int i = 0; i < 10; i++) begin
                inj_line = (i < his[p]);
                @(negedge clk);
            end
        end
        inj_line = 1'b0;
        wait_clk(30);
        inj_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wait_clk(3);
        check("R1", "line during reset", int'(line_out), 0);
        check("R3", "strobe during reset", int'(sync_strobe), 0);
        check("R6", "error during reset", int'(pattern_err), 0);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic t_idle();
        mode = 2'd0;
        clear_mon();
        wait_clk(100);
        check("R1", "idle stretched periods", n7, 0);
        check("R1", "idle bad runs", bad_run, 0);
        check("R1", "idle bad periods", bad_per, 0);
        check("R1", "idle normal runs >= 8", int'(n3 >= 8), 1);
        check("R1", "idle strobes", n_strobe, 0);
    endtask

    task automatic t_single();
        mode = 2'd0;
        clear_mon();
        pulse_req();
        wait_clk(60);
        check("R2", "stretched periods", n7, 1);
        check("R2", "period length", bad_per, 0);
        check("R3", "strobe count", n_strobe, 1);
        check("R3", "strobe delay after fall", last_delta, 2);
        check("R3", "strobe length", last_slen, 10);
    endtask

    task automatic t_midcycle();
        mode = 2'd0;
        clear_mon();
        for (int k = 0; k < 10; k++) begin
            wait_rise();
            wait_clk(k);
            pulse_req();
            wait_clk(40);
        end
        check("R4", "stretched periods", n7, 10);
        check("R4", "truncated runs", bad_run, 0);
        check("R4", "bad periods", bad_per, 0);
        check("R4", "strobes", n_strobe, 10);
    endtask

    task automatic t_couplet();
        int idx;
        mode = 2'd1;
        clear_mon();
        pulse_req();
        wait_clk(80);
        idx = 0;
        while (idx < 13 && runlog[idx] != 7) idx++;
        check("R5", "stretched periods", n7, 2);
        check("R5", "second run", runlog[idx + 1], 7);
        check("R5", "closing run", runlog[idx + 2], 3);
        check("R5", "strobes", n_strobe, 1);
        check("R5", "errors", n_perr, 0);
        mode = 2'd0;
    endtask

    task automatic t_couplet_err();
        int a [5] = '{3, 7, 3, 3, 3};
        int b [5] = '{3, 7, 7, 7, 3};
        mode = 2'd1;
        clear_mon();
        inj_seq(a, 5);
        check("R6", "missing pair strobes", n_strobe, 1);
        check("R6", "missing pair errors", n_perr, 1);
        check("R6", "error length", last_elen, 10);
        clear_mon();
        inj_seq(b, 5);
        check("R6", "extra high strobes", n_strobe, 1);
        check("R6", "extra high errors", n_perr, 1);
        mode = 2'd0;
    endtask

    task automatic t_square();
        mode = 2'd2;
        clear_mon();
        wait_clk(1200);
        pulse_req();
        wait_clk(1800);
        check("R7", "envelope spacing errors", sp_bad, 0);
        check("R7", "envelope edges >= 4", int'(sp_ok >= 4), 1);
        check("R7", "period length", bad_per, 0);
        check("R7", "errors", n_perr, 0);
        mode = 2'd0;
        wait_clk(40);
        clear_mon();
        wait_clk(200);
        check("R8", "stretched after square", n7, 0);
        check("R8", "strobes after square", n_strobe, 0);
    endtask

    task automatic t_reset_mid();
        mode = 2'd0;
        pulse_req();
        wait_rise();
        wait_clk(3);
        rst = 1'b1;
        wait_clk(2);
        check("R9", "line in reset", int'(line_out), 0);
        rst = 1'b0;
        clear_mon();
        wait_clk(80);
        check("R9", "stretched after reset", n7, 0);
        check("R9", "normal runs >= 6", int'(n3 >= 6), 1);
        check("R9", "strobes", n_strobe, 0);
        check("R9", "bad runs", bad_run, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_single();
        t_midcycle();
        t_couplet();
        t_couplet_err();
        t_square();
        t_reset_mid();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule